// File: doc/BRIEF.md
# Windowed Clock Frequency Monitor

This block checks the rate of a monitored clock against a reference clock. It opens a measurement window of programmable length and counts events inside it. When the window closes, it copies the count into a buffer and compares that value with four limits. Each limit that is crossed sets its own sticky flag. Two limits are warning limits and two are failing limits. When fail-safe mode is on, a failing result also raises a request to switch to a backup clock. All logic runs on the reference clock. The monitored clock goes through a two-stage synchronizer and a rising-edge detector, so its frequency has to stay below half the reference rate.

A small state machine sequences the windows. It has three states:
- HOLD: idle. The window counter and the accumulator are held at zero.
- START: lasts one cycle and arms a new series of windows.
- COUNT: windows run back to back.

The transitions are:
- HOLD→START when hold is released.
- START→COUNT when hold stays low.
- START→HOLD and COUNT→HOLD when hold is asserted.
- COUNT→COUNT at every window end. This is the restart.

In normal mode the window lasts a set number of reference cycles, and the accumulator counts monitored rising edges. In pulse-width mode the roles swap. The window lasts a set number of monitored rising edges, and the accumulator counts reference cycles.

Software drives the limits, the mode and the hold level. It clears the sticky flags by pulsing bits of a clear vector (write one to clear). A fault input lets a test force a failing result.

Top module: `clkmon_freq_checker`

## Requirements
- R1: In normal mode, each window spans max(`win_len`,1) reference cycles and windows follow one another with no gap. The captured value is the number of monitored rising edges inside the window.
- R2: In pulse-width mode (`pulse_mode`=1), each window spans `win_len` monitored rising edges. The captured value is the number of reference cycles in that span.
- R3: While `hold_rst` is high, the state machine stays in HOLD, no capture occurs, and the counters are zero. After release it spends one cycle in START and then enters COUNT.
- R4: The accumulator never goes past `sat_lim`. When an increment reaches `sat_lim`, the saturation flag is set.
- R5: At every window end, `buf_data` loads the window count and `capture_stb` pulses for one cycle, both at the same clock edge.
- R6: `buf_valid` is set at a window end unless both that window and the window before it saw no monitored edge. It is set again by the first window that has edges.
- R7: A captured value above `hwarn_lim` sets `hwarn_flag`. A value below `lwarn_lim` sets `lwarn_flag`.
- R8: A captured value above `hfail_lim` sets `hfail_flag`. A value below `lfail_lim` sets `lfail_flag`. `switch_req` is high exactly when `failsafe_en` is high and either failing flag is set.
- R9: `trig_flag` is set on the START cycle, on every window end, and when hold stops an active sequence.
- R10: A `fault_req` pulse sets `lfail_flag` only when all four limit flags are clear. Otherwise it has no effect.
- R11: All flags are sticky until they are cleared through `flag_clr`. The bit map of `flag_clr` is in the table below. If a flag is set and cleared in the same cycle, the set wins.

| `flag_clr` bit | Flag cleared |
|---|---|
| 0 | `buf_valid` |
| 1 | `sat_flag` |
| 2 | `trig_flag` |
| 3 | `lfail_flag` |
| 4 | `hfail_flag` |
| 5 | `lwarn_flag` |
| 6 | `hwarn_flag` |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_clk | input | 1 | Clock under observation |
| hold_rst | input | 1 | Holds the window generator and accumulator in reset |
| pulse_mode | input | 1 | Swaps the roles of the two clocks |
| failsafe_en | input | 1 | Lets a failing flag raise `switch_req` |
| win_len | input | 32 | Window length in ticks |
| sat_lim | input | 32 | Accumulator ceiling |
| hwarn_lim | input | 32 | High warning limit |
| lwarn_lim | input | 32 | Low warning limit |
| hfail_lim | input | 32 | High failing limit |
| lfail_lim | input | 32 | Low failing limit |
| fault_req | input | 1 | Fault-injection request pulse |
| flag_clr | input | 7 | Per-flag write-one-to-clear pulses |
| buf_data | output | 32 | Last captured count |
| capture_stb | output | 1 | One-cycle pulse when `buf_data` loads |
| buf_valid | output | 1 | Sticky flag: a valid count was captured |
| sat_flag | output | 1 | Sticky flag: the accumulator reached its ceiling |
| trig_flag | output | 1 | Sticky flag: a window started, restarted or stopped |
| lfail_flag | output | 1 | Sticky low failing flag |
| hfail_flag | output | 1 | Sticky high failing flag |
| lwarn_flag | output | 1 | Sticky low warning flag |
| hwarn_flag | output | 1 | Sticky high warning flag |
| switch_req | output | 1 | Request to switch to the backup clock |

## Verification
A window end updates `buf_data`, `capture_stb` and every flag that depends on the count, all at the same reference edge. A `fault_req`, a clear pulse or a hold edge driven before a rising edge shows its effect right after that edge. The bench drives inputs at falling edges and samples at the next falling edge, or at the falling edge where `capture_stb` is seen.

The bench starts every run from HOLD and generates the monitored clock with a period that divides the window. This makes every normal-mode window hold an exact, known number of edges. In pulse-width mode the first window after START depends on phase, so the scoreboard skips that capture.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
    typedef enum logic [1:0] {
        ST_HOLD,
        ST_START,
        ST_COUNT
    } win_state_e;

    // positions in the flag / clear vectors
    localparam int FL_BUFV  = 0;
    localparam int FL_SAT   = 1;
    localparam int FL_TRIG  = 2;
    localparam int FL_LFAIL = 3;
    localparam int FL_HFAIL = 4;
    localparam int FL_LWARN = 5;
    localparam int FL_HWARN = 6;
    localparam int NUM_FLAGS = 7;
endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= async_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/clkmon_window_fsm.sv
module clkmon_window_fsm
    import clkmon_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         tick,
    input  logic [W-1:0] win_len,
    output logic         win_end,
    output logic         in_start,
    output logic         in_count,
    output logic         stop_evt
);
    win_state_e   state_q, state_d;
    logic [W-1:0] wcnt_q;
    logic [W:0]   wcnt_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (!hold) state_d = ST_START;
            ST_START: state_d = hold ? ST_HOLD : ST_COUNT;
            ST_COUNT: if (hold) state_d = ST_HOLD;
            default:  state_d = ST_HOLD;
        endcase
    end

    assign wcnt_inc = {1'b0, wcnt_q} + 1'b1;

    always_comb begin
        in_start = (state_q == ST_START);
        in_count = (state_q == ST_COUNT);
        stop_evt = (state_q != ST_HOLD) && hold;
        win_end  = in_count && !hold && tick && (wcnt_inc >= {1'b0, win_len});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  wcnt_q <= '0;
        else if (!in_count)          wcnt_q <= '0;
        else if (win_end)            wcnt_q <= '0;
        else if (tick)               wcnt_q <= wcnt_inc[W-1:0];
    end

    // R1: window position stays inside the programmed length
    assert_win_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_count && $past(wcnt_q) < $past(win_len) && $stable(win_len))
            |-> (wcnt_q < win_len));

    // R3: the START state always lasts exactly one cycle
    assert_start_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_start |=> !in_start);
endmodule

// File: rtl/clkmon_accum.sv
module clkmon_accum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    input  logic         win_end,
    input  logic [W-1:0] sat_lim,
    output logic [W-1:0] acc_next,
    output logic         sat_hit
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    assign sum      = {1'b0, acc_q} + {{W{1'b0}}, inc};
    assign acc_next = (sum >= {1'b0, sat_lim}) ? sat_lim : sum[W-1:0];
    assign sat_hit  = inc && (acc_next == sat_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               acc_q <= '0;
        else if (clear || win_end) acc_q <= '0;
        else                      acc_q <= acc_next;
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_q) <= $past(sat_lim) && $stable(sat_lim)) |-> (acc_q <= sat_lim));
endmodule

// File: rtl/clkmon_freq_checker.sv
module clkmon_freq_checker
    import clkmon_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int SYNC_STG   = 2,
    parameter int DEAD_LIMIT = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             mon_clk,
    input  logic             hold_rst,
    input  logic             pulse_mode,
    input  logic             failsafe_en,
    input  logic [CNT_W-1:0] win_len,
    input  logic [CNT_W-1:0] sat_lim,
    input  logic [CNT_W-1:0] hwarn_lim,
    input  logic [CNT_W-1:0] lwarn_lim,
    input  logic [CNT_W-1:0] hfail_lim,
    input  logic [CNT_W-1:0] lfail_lim,
    input  logic             fault_req,
    input  logic [6:0]       flag_clr,
    output logic [CNT_W-1:0] buf_data,
    output logic             capture_stb,
    output logic             buf_valid,
    output logic             sat_flag,
    output logic             trig_flag,
    output logic             lfail_flag,
    output logic             hfail_flag,
    output logic             lwarn_flag,
    output logic             hwarn_flag,
    output logic             switch_req
);
    localparam int DW = $clog2(DEAD_LIMIT + 1);

    logic             mon_rise, tick, inc;
    logic             win_end, in_start, in_count, stop_evt;
    logic [CNT_W-1:0] acc_next;
    logic             sat_hit;
    logic             edge_seen_q, win_zero, dead;
    logic [DW-1:0]    dead_cnt_q;
    logic [NUM_FLAGS-1:0] flags_q, flag_set;
    logic             fault_ok;
    logic [CNT_W-1:0] buf_q;
    logic             cap_q;

    clkmon_edge_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(ref_clk), .rst_n(rst_n), .async_in(mon_clk), .rise(mon_rise)
    );

    // role swap: window ticks and count increments
    assign tick = pulse_mode ? mon_rise : 1'b1;
    assign inc  = in_count && (pulse_mode ? 1'b1 : mon_rise);

    clkmon_window_fsm #(.W(CNT_W)) u_fsm (
        .clk(ref_clk), .rst_n(rst_n), .hold(hold_rst), .tick(tick),
        .win_len(win_len), .win_end(win_end), .in_start(in_start),
        .in_count(in_count), .stop_evt(stop_evt)
    );

    clkmon_accum #(.W(CNT_W)) u_acc (
        .clk(ref_clk), .rst_n(rst_n), .clear(!in_count), .inc(inc),
        .win_end(win_end), .sat_lim(sat_lim), .acc_next(acc_next),
        .sat_hit(sat_hit)
    );

    // dead-clock watchdog: consecutive windows without a monitored edge
    assign win_zero = !pulse_mode && !(edge_seen_q || mon_rise);
    assign dead     = win_zero && (dead_cnt_q >= DW'(DEAD_LIMIT - 1));

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_seen_q <= 1'b0;
            dead_cnt_q  <= '0;
        end else if (!in_count) begin
            edge_seen_q <= 1'b0;
            dead_cnt_q  <= '0;
        end else if (win_end) begin
            edge_seen_q <= 1'b0;
            if (!win_zero)                          dead_cnt_q <= '0;
            else if (dead_cnt_q < DW'(DEAD_LIMIT))  dead_cnt_q <= dead_cnt_q + 1'b1;
        end else if (mon_rise) begin
            edge_seen_q <= 1'b1;
        end
    end

    // capture path
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            cap_q <= 1'b0;
        end else begin
            cap_q <= win_end;
            if (win_end) buf_q <= acc_next;
        end
    end

    // sticky flags
    assign fault_ok = fault_req && !(flags_q[FL_LFAIL] || flags_q[FL_HFAIL] ||
                                     flags_q[FL_LWARN] || flags_q[FL_HWARN]);

    always_comb begin
        flag_set           = '0;
        flag_set[FL_BUFV]  = win_end && !dead;
        flag_set[FL_SAT]   = sat_hit;
        flag_set[FL_TRIG]  = in_start || win_end || stop_evt;
        flag_set[FL_LFAIL] = (win_end && (acc_next < lfail_lim)) || fault_ok;
        flag_set[FL_HFAIL] = win_end && (acc_next > hfail_lim);
        flag_set[FL_LWARN] = win_end && (acc_next < lwarn_lim);
        flag_set[FL_HWARN] = win_end && (acc_next > hwarn_lim);
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flag_set | (flags_q & ~flag_clr);
    end

    assign buf_data    = buf_q;
    assign capture_stb = cap_q;
    assign buf_valid   = flags_q[FL_BUFV];
    assign sat_flag    = flags_q[FL_SAT];
    assign trig_flag   = flags_q[FL_TRIG];
    assign lfail_flag  = flags_q[FL_LFAIL];
    assign hfail_flag  = flags_q[FL_HFAIL];
    assign lwarn_flag  = flags_q[FL_LWARN];
    assign hwarn_flag  = flags_q[FL_HWARN];
    assign switch_req  = failsafe_en && (flags_q[FL_LFAIL] || flags_q[FL_HFAIL]);

    assert_hold_quiet_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        hold_rst |=> !capture_stb);

    assert_capture_in_count_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        capture_stb |-> $past(in_count));

    assert_warn_sticky_R11: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($past(hwarn_flag) && !$past(flag_clr[FL_HWARN])) |-> hwarn_flag);

    assert_start_trig_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        in_start |=> trig_flag);

    assert_fault_blocked_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (fault_req && !lfail_flag && !win_end && (hfail_flag || lwarn_flag || hwarn_flag))
            |=> !lfail_flag);

    assert_failover_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (failsafe_en && $rose(hfail_flag)) |-> switch_req);
endmodule

// File: tb/clkmon_freq_checker_test.sv
module clkmon_freq_checker_test;
    logic        ref_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mon_clk = 1'b0;
    logic        hold_rst = 1'b1;
    logic        pulse_mode = 1'b0;
    logic        failsafe_en = 1'b1;
    logic [31:0] win_len = 32'd64;
    logic [31:0] sat_lim = 32'd1000;
    logic [31:0] hwarn_lim = 32'd10;
    logic [31:0] lwarn_lim = 32'd6;
    logic [31:0] hfail_lim = 32'd20;
    logic [31:0] lfail_lim = 32'd2;
    logic        fault_req = 1'b0;
    logic [6:0]  flag_clr = 7'd0;
    logic [31:0] buf_data;
    logic        capture_stb, buf_valid, sat_flag, trig_flag;
    logic        lfail_flag, hfail_flag, lwarn_flag, hwarn_flag, switch_req;

    int n_cmp = 0;
    int n_bad = 0;
    int mon_half = 4;
    bit mon_run = 1'b0;
    int mon_ctr = 0;
    int cap_cnt = 0;
    int skip_upto = 0;
    logic [31:0] exp_q[$];
    string exp_req = "R1";

    always #5 ref_clk = ~ref_clk;

    clkmon_freq_checker uut (
        .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk), .hold_rst(hold_rst),
        .pulse_mode(pulse_mode), .failsafe_en(failsafe_en), .win_len(win_len),
        .sat_lim(sat_lim), .hwarn_lim(hwarn_lim), .lwarn_lim(lwarn_lim),
        .hfail_lim(hfail_lim), .lfail_lim(lfail_lim), .fault_req(fault_req),
        .flag_clr(flag_clr), .buf_data(buf_data), .capture_stb(capture_stb),
        .buf_valid(buf_valid), .sat_flag(sat_flag), .trig_flag(trig_flag),
        .lfail_flag(lfail_flag), .hfail_flag(hfail_flag), .lwarn_flag(lwarn_flag),
        .hwarn_flag(hwarn_flag), .switch_req(switch_req)
    );

    // monitored clock, period 2*mon_half reference cycles
    always @(negedge ref_clk) begin
        if (!mon_run) begin
            mon_clk <= 1'b0;
            mon_ctr <= 0;
        end else if (mon_ctr >= mon_half - 1) begin
            mon_ctr <= 0;
            mon_clk <= ~mon_clk;
        end else begin
            mon_ctr <= mon_ctr + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge ref_clk) begin
        if (rst_n && capture_stb) begin
            cap_cnt <= cap_cnt + 1;
            if (cap_cnt >= skip_upto && exp_q.size() > 0) begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(buf_data == e, exp_req, "captured count", buf_data, e);
            end
        end
    end

    task automatic wait_cap();
        do @(negedge ref_clk); while (!capture_stb);
    endtask

    task automatic clear_all();
        flag_clr = 7'h7F;
        @(negedge ref_clk);
        flag_clr = 7'h00;
    endtask

    // driver: configure in HOLD, release, push expected captures, wait for drain
    task automatic run_case(input string req, input int half, input bit pm,
                            input int n, input logic [31:0] expv);
        @(negedge ref_clk);
        hold_rst = 1'b1;
        mon_half = half;
        pulse_mode = pm;
        mon_run = 1'b1;
        repeat (40) @(negedge ref_clk);
        clear_all();
        exp_req = req;
        skip_upto = pm ? cap_cnt + 1 : cap_cnt;
        for (int i = 0; i < n; i++) exp_q.push_back(expv);
        hold_rst = 1'b0;
        while (exp_q.size() > 0) @(negedge ref_clk);
    endtask

    initial begin
        repeat (150000) @(posedge ref_clk);
        chk(1'b0, "WATCHDOG", "run timed out", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int c0;
        repeat (3) @(negedge ref_clk);
        rst_n = 1'b1;
        @(negedge ref_clk);
        // reset state
        chk(buf_data == 0 && !capture_stb, "R5", "reset buffer", buf_data, 0);
        chk({buf_valid, sat_flag, trig_flag, lfail_flag, hfail_flag, lwarn_flag,
             hwarn_flag, switch_req} == 8'd0, "R11", "reset flags",
            {buf_valid, sat_flag, trig_flag, lfail_flag, hfail_flag, lwarn_flag,
             hwarn_flag, switch_req}, 0);

        // R1: 8 edges per 64-cycle window, inside all limits
        run_case("R1", 4, 1'b0, 3, 32'd8);
        chk(buf_valid, "R5", "buf_valid after capture", buf_valid, 1);
        chk(trig_flag, "R9", "trig after windows", trig_flag, 1);
        chk(!hwarn_flag && !lwarn_flag, "R7", "no warning in range",
            {hwarn_flag, lwarn_flag}, 0);

        // R7: 16 edges exceed warning but not failing limit
        run_case("R1", 2, 1'b0, 2, 32'd16);
        chk(hwarn_flag && !hfail_flag, "R7", "high warning only",
            {hwarn_flag, hfail_flag}, 2'b10);

        // R7/R8: 4 edges under low warning, above low failing
        run_case("R1", 8, 1'b0, 2, 32'd4);
        chk(lwarn_flag && !lfail_flag, "R7", "low warning only",
            {lwarn_flag, lfail_flag}, 2'b10);
        chk(!switch_req, "R8", "no switch without failing", switch_req, 0);

        // R8: high failing with 32 edges
        hfail_lim = 32'd20;
        run_case("R8", 2, 1'b0, 1, 32'd16);
        win_len = 32'd128;
        run_case("R8", 2, 1'b0, 1, 32'd32);
        chk(hfail_flag && switch_req, "R8", "high failing and switch",
            {hfail_flag, switch_req}, 2'b11);
        win_len = 32'd64;

        // R4: saturation at 5
        sat_lim = 32'd5;
        run_case("R4", 2, 1'b0, 2, 32'd5);
        chk(sat_flag, "R4", "saturation flag", sat_flag, 1);
        sat_lim = 32'd1000;

        // R2: pulse-width mode, 4 monitored edges of period 8 -> 32 cycles
        win_len = 32'd4;
        hwarn_lim = 32'd40; lwarn_lim = 32'd20; hfail_lim = 32'd100; lfail_lim = 32'd1;
        run_case("R2", 4, 1'b1, 3, 32'd32);
        chk(!hwarn_flag && !lwarn_flag, "R2", "pulse count in range",
            {hwarn_flag, lwarn_flag}, 0);

        // R3: hold stops captures, sets trig on stop
        @(negedge ref_clk);
        hold_rst = 1'b1;
        flag_clr = 7'b0000100;
        @(negedge ref_clk);
        flag_clr = 7'd0;
        chk(trig_flag, "R9", "trig on stop (set beats clear)", trig_flag, 1);
        c0 = cap_cnt;
        repeat (300) @(negedge ref_clk);
        chk(cap_cnt == c0, "R3", "no capture during hold", cap_cnt - c0, 0);
        clear_all();
        chk(!trig_flag, "R11", "trig cleared in hold", trig_flag, 0);

        // R6: dead monitored clock, normal mode
        win_len = 32'd64; pulse_mode = 1'b0; lfail_lim = 32'd2;
        hwarn_lim = 32'd10; lwarn_lim = 32'd6; hfail_lim = 32'd20;
        mon_half = 4;
        repeat (40) @(negedge ref_clk);
        hold_rst = 1'b0;
        wait_cap();
        mon_run = 1'b0;
        wait_cap();
        wait_cap();
        clear_all();
        wait_cap();
        chk(!buf_valid, "R6", "buf_valid suppressed on dead clock", buf_valid, 0);
        chk(buf_data == 0, "R6", "dead window count", buf_data, 0);
        chk(lfail_flag && switch_req, "R8", "low failing and switch",
            {lfail_flag, switch_req}, 2'b11);
        mon_run = 1'b1;
        wait_cap();
        chk(buf_valid, "R6", "buf_valid returns", buf_valid, 1);

        // R10: fault injection with flags clear
        @(negedge ref_clk);
        hold_rst = 1'b1;
        repeat (5) @(negedge ref_clk);
        clear_all();
        fault_req = 1'b1;
        @(negedge ref_clk);
        fault_req = 1'b0;
        chk(lfail_flag && switch_req, "R10", "fault accepted",
            {lfail_flag, switch_req}, 2'b11);

        // R10: fault ignored while a warning is set
        hwarn_lim = 32'd5;
        run_case("R7", 4, 1'b0, 1, 32'd8);
        @(negedge ref_clk);
        hold_rst = 1'b1;
        repeat (5) @(negedge ref_clk);
        flag_clr = 7'b0001000;
        @(negedge ref_clk);
        flag_clr = 7'd0;
        fault_req = 1'b1;
        @(negedge ref_clk);
        fault_req = 1'b0;
        @(negedge ref_clk);
        chk(!lfail_flag && hwarn_flag, "R10", "fault ignored with warning",
            {lfail_flag, hwarn_flag}, 2'b01);

        // R11: clear a single flag bit
        flag_clr = 7'b1000000;
        @(negedge ref_clk);
        flag_clr = 7'd0;
        chk(!hwarn_flag && buf_valid, "R11", "single bit clear",
            {hwarn_flag, buf_valid}, 2'b01);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule